// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of an on-chip flash array and watches 32-bit bus writes aimed at the flash address window. Commands are never issued through a register: software performs a short chain of writes, each carrying an exact data value to an exact offset. The decoder recognises these chains, starts the matching operation and reports the result in a 32-bit status word that software reads back through the normal read path.

Recognised commands are: a single-write status clear, a single-write entry into page mode, paired writes that fill a page buffer, a four-write page program, a six-write sector erase (normal sector or configuration block) and a six-write temporary unprotect that checks a user level and two passwords. A program or erase keeps the busy flag raised for a fixed, parameterised number of clock cycles. Any write that does not fit the expected chain aborts it and raises a sticky sequence-error flag; an operation aimed at a locked sector raises a protection-error flag instead of starting.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every status bit is 0.
- R2: The writes 0xAA@0x5554, 0x55@0xAAA8, 0x80@0x5554, 0xAA@0x5554, 0x55@0xAAA8, then 0x30 (normal sector) or 0xC0 (configuration block) to an address whose low SECT_SHIFT bits are zero start an erase: status bit 5 (erase started) and bit 0 (busy) are set one cycle after the last write.
- R3: Status bit 0 stays high for exactly BUSY_CYC cycles after an operation starts and then clears by itself.
- R4: Writing 0xF5 to offset 0x5554 from idle clears status bits 4, 5, 6, 10 and 11 and leaves bit 25 unchanged.
- R5: Writing 0x50 to 0x5554 sets page mode (bit 6); buffer loads are a low word at 0x55F0 followed by a high word at 0x55F4, and PAGE_PAIRS such pairs fill the buffer.
- R6: With page mode active and a full buffer, 0xAA@0x5554, 0x55@0xAAA8, 0xA0 or 0xC0 @0x5554, then 0xAA to a page-aligned address (low log2(PAGE_PAIRS*8) bits zero) start a program: bit 4 and bit 0 set, bit 6 cleared.
- R7: A page program issued without page mode, or with fewer than PAGE_PAIRS pairs loaded, sets bit 10 and starts nothing; a low load twice in a row, or any load outside page mode, also sets bit 10.
- R8: A write with an unexpected address or data at any step sets bit 10 and returns the decoder to idle, so a following correct chain is accepted.
- R9: Any write while bit 0 is set sets bit 10 and starts no operation.
- R10: A normal erase or program whose target sector (address bits above SECT_SHIFT) has its sect_lock bit set, while bit 25 is clear, sets bit 11 and does not set bit 0.
- R11: The writes 0xAA@0x5554, 0x55@0xAAA8, level@0x553C, password 1@0xAAA8, password 2@0xAAA8, 0x05@0x5558 set bit 25 only when both passwords equal pw1 and pw2; a mismatch leaves bit 25 unchanged without an error.
- R12: A user level above 2 in the unprotect chain sets bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one bus write |
| wr_addr | input | ADDR_W | Byte offset of the write inside the flash window |
| wr_data | input | 32 | Write data |
| sect_lock | input | 2**(ADDR_W-SECT_SHIFT) | Per-sector write-protection bits |
| pw1 | input | 32 | Expected first password |
| pw2 | input | 32 | Expected second password |
| status | output | 32 | Status word: bit 0 busy, 4 program, 5 erase, 6 page mode, 10 sequence error, 11 protection error, 25 protection disabled |

## Verification
A decoder left in the wrong step shows up on the very next write: a valid command is then flagged as a sequence error in status bit 10 one cycle after it, or a broken chain starts an operation it should not. A wrong page-buffer count only appears at the page-program write, which is then refused or accepted against expectation, so the bench loads exact pair counts on both sides of the limit. A busy timer off by one is visible as a busy pulse one cycle too long or too short, which the bench measures edge by edge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int unsigned OFF_UNLOCK = 32'h5554;
    localparam int unsigned OFF_ALT    = 32'hAAA8;
    localparam int unsigned OFF_LOAD_L = 32'h55F0;
    localparam int unsigned OFF_LOAD_H = 32'h55F4;
    localparam int unsigned OFF_LEVEL  = 32'h553C;
    localparam int unsigned OFF_TRIG   = 32'h5558;

    localparam int BIT_BUSY   = 0;
    localparam int BIT_PROG   = 4;
    localparam int BIT_ERASE  = 5;
    localparam int BIT_PMODE  = 6;
    localparam int BIT_SEQERR = 10;
    localparam int BIT_PROERR = 11;
    localparam int BIT_UNPROT = 25;

    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL1, ST_UNL2,
        ST_ERS3, ST_ERS4, ST_ERS5,
        ST_PGM3,
        ST_UNP3, ST_UNP4, ST_UNP5
    } step_e;

    typedef struct packed {
        step_e st;
        logic  cfg;
        logic  pwa_ok;
        logic  pw_ok;
        logic  pmode;
        logic  prog;
        logic  erase;
        logic  seqerr;
        logic  proerr;
        logic  unprot;
    } dec_s;

endpackage

// File: rtl/fcd_pair_counter.sv
module fcd_pair_counter #(
    parameter int PAGE_PAIRS = 32,
    localparam int CNT_W = $clog2(PAGE_PAIRS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lo_stb,
    input  logic hi_stb,
    output logic half,
    output logic full
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
    } pc_s;

    pc_s q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (lo_stb) begin
            d.half = 1'b1;
        end else if (hi_stb) begin
            d.half = 1'b0;
            d.cnt  = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign half = q.half;
    assign full = (q.cnt == CNT_W'(PAGE_PAIRS));
endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
    parameter int BUSY_CYC = 8,
    localparam int TW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [TW-1:0] left;
        logic          busy;
    } bt_s;

    bt_s q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.left = TW'(BUSY_CYC - 1);
        end else if (q.busy) begin
            if (q.left == '0) d.busy = 1'b0;
            else              d.left = q.left - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SECT_SHIFT = 14,
    parameter int PAGE_PAIRS = 32,
    parameter int BUSY_CYC   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [31:0]                            wr_data,
    input  logic [(1<<(ADDR_W-SECT_SHIFT))-1:0]    sect_lock,
    input  logic [31:0]                            pw1,
    input  logic [31:0]                            pw2,
    output logic [31:0]                            status
);
    localparam int SECT_W     = ADDR_W - SECT_SHIFT;
    localparam int PAGE_SHIFT = $clog2(PAGE_PAIRS * 8);
    localparam logic [ADDR_W-1:0] A_UNL = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_ALT = ADDR_W'(OFF_ALT);
    localparam logic [ADDR_W-1:0] A_LDL = ADDR_W'(OFF_LOAD_L);
    localparam logic [ADDR_W-1:0] A_LDH = ADDR_W'(OFF_LOAD_H);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_TRG = ADDR_W'(OFF_TRIG);

    dec_s q, d;
    logic lo_stb, hi_stb, pclr, start;
    logic buf_half, buf_full, busy;
    logic bad, locked;
    logic [SECT_W-1:0] sect;

    fcd_pair_counter #(.PAGE_PAIRS(PAGE_PAIRS)) u_pairs (
        .clk(clk), .rst_n(rst_n), .clr(pclr),
        .lo_stb(lo_stb), .hi_stb(hi_stb),
        .half(buf_half), .full(buf_full)
    );

    fcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    assign sect   = wr_addr[ADDR_W-1:SECT_SHIFT];
    assign locked = sect_lock[sect] && !q.unprot;

    always_comb begin
        d      = q;
        lo_stb = 1'b0;
        hi_stb = 1'b0;
        pclr   = 1'b0;
        start  = 1'b0;
        bad    = 1'b0;
        if (wr_en) begin
            d.st = ST_IDLE;
            if (busy) begin
                bad = 1'b1;
            end else begin
                unique case (q.st)
                    ST_IDLE: begin
                        if (wr_addr == A_UNL && wr_data == 32'hAA) begin
                            d.st = ST_UNL1;
                        end else if (wr_addr == A_UNL && wr_data == 32'hF5) begin
                            d.prog = 1'b0; d.erase = 1'b0; d.pmode = 1'b0;
                            d.seqerr = 1'b0; d.proerr = 1'b0;
                            pclr = 1'b1;
                        end else if (wr_addr == A_UNL && wr_data == 32'h50) begin
                            d.pmode = 1'b1;
                            pclr    = 1'b1;
                        end else if (wr_addr == A_LDL && q.pmode && !buf_half && !buf_full) begin
                            lo_stb = 1'b1;
                        end else if (wr_addr == A_LDH && q.pmode && buf_half) begin
                            hi_stb = 1'b1;
                        end else begin
                            bad = 1'b1;
                        end
                    end
                    ST_UNL1: begin
                        if (wr_addr == A_ALT && wr_data == 32'h55) d.st = ST_UNL2;
                        else bad = 1'b1;
                    end
                    ST_UNL2: begin
                        if (wr_addr == A_UNL && wr_data == 32'h80) begin
                            d.st = ST_ERS3;
                        end else if (wr_addr == A_UNL && (wr_data == 32'hA0 || wr_data == 32'hC0)) begin
                            d.st  = ST_PGM3;
                            d.cfg = (wr_data == 32'hC0);
                        end else if (wr_addr == A_LVL && wr_data <= 32'd2) begin
                            d.st = ST_UNP3;
                        end else begin
                            bad = 1'b1;
                        end
                    end
                    ST_ERS3: begin
                        if (wr_addr == A_UNL && wr_data == 32'hAA) d.st = ST_ERS4;
                        else bad = 1'b1;
                    end
                    ST_ERS4: begin
                        if (wr_addr == A_ALT && wr_data == 32'h55) d.st = ST_ERS5;
                        else bad = 1'b1;
                    end
                    ST_ERS5: begin
                        if (wr_addr[SECT_SHIFT-1:0] != '0 ||
                            !(wr_data == 32'h30 || wr_data == 32'hC0)) begin
                            bad = 1'b1;
                        end else if (wr_data == 32'h30 && locked) begin
                            d.proerr = 1'b1;
                        end else begin
                            d.erase = 1'b1;
                            start   = 1'b1;
                        end
                    end
                    ST_PGM3: begin
                        if (wr_addr[PAGE_SHIFT-1:0] != '0 || wr_data != 32'hAA ||
                            !q.pmode || !buf_full || buf_half) begin
                            bad = 1'b1;
                        end else if (!q.cfg && locked) begin
                            d.proerr = 1'b1;
                        end else begin
                            d.prog  = 1'b1;
                            d.pmode = 1'b0;
                            pclr    = 1'b1;
                            start   = 1'b1;
                        end
                    end
                    ST_UNP3: begin
                        if (wr_addr == A_ALT) begin
                            d.st     = ST_UNP4;
                            d.pwa_ok = (wr_data == pw1);
                        end else bad = 1'b1;
                    end
                    ST_UNP4: begin
                        if (wr_addr == A_ALT) begin
                            d.st    = ST_UNP5;
                            d.pw_ok = q.pwa_ok && (wr_data == pw2);
                        end else bad = 1'b1;
                    end
                    ST_UNP5: begin
                        if (wr_addr == A_TRG && wr_data == 32'h05) begin
                            if (q.pw_ok) d.unprot = 1'b1;
                        end else bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
            end
            if (bad) d.seqerr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        status             = '0;
        status[BIT_BUSY]   = busy;
        status[BIT_PROG]   = q.prog;
        status[BIT_ERASE]  = q.erase;
        status[BIT_PMODE]  = q.pmode;
        status[BIT_SEQERR] = q.seqerr;
        status[BIT_PROERR] = q.proerr;
        status[BIT_UNPROT] = q.unprot;
    end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W   = 18,
    parameter int BUSY_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       status
);
    localparam int RW = $clog2(BUSY_CYC + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        run_q <= '0;
        else if (!status[0])               run_q <= '0;
        else if (run_q != RW'(BUSY_CYC + 1)) run_q <= run_q + RW'(1);
    end

    // R1: reset leaves a clean status word
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> status == 32'h0);

    // R3: a busy pulse never outlasts its programmed length
    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> run_q < RW'(BUSY_CYC));

    // R9: a write during busy is flagged
    a_r9_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && status[0]) |=> status[10]);

    // R6: programming only ever starts from page mode
    a_r6_prog_needs_pmode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(status[6]));

    // R10: a protection refusal never coincides with a start
    a_r10_proerr_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[11]) |-> !$rose(status[0]));

    // R11: protection is only lifted by the final unprotect write
    a_r11_unprot_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[25]) |-> $past(wr_en && wr_addr == ADDR_W'(32'h5558) && wr_data == 32'h05));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status(status)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
    localparam int ADDR_W = 18;
    localparam int BUSY   = 8;
    localparam int PAIRS  = 32;
    localparam logic [31:0] PWA = 32'h1234_5678;
    localparam logic [31:0] PWB = 32'hCAFE_0042;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] sect_lock = '0;
    logic [31:0] status;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_SHIFT(14), .PAGE_PAIRS(PAIRS), .BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sect_lock(sect_lock), .pw1(PWA), .pw2(PWB), .status(status)
    );

    typedef struct packed {
        logic [17:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam vec_t VECS [17] = '{
        '{18'h05554, 32'h50, 32'h040, 4'd5},   // R5 page mode
        '{18'h05554, 32'hF5, 32'h000, 4'd4},   // R4 clear
        '{18'h01234, 32'hAA, 32'h400, 4'd8},   // R8 stray address
        '{18'h05554, 32'hF5, 32'h000, 4'd4},   // R4
        '{18'h05554, 32'hAA, 32'h000, 4'd8},   // R8 chain step 1
        '{18'h0AAA8, 32'h55, 32'h000, 4'd8},   // R8 chain step 2
        '{18'h05554, 32'h77, 32'h400, 4'd8},   // R8 wrong data mid-chain
        '{18'h05554, 32'hF5, 32'h000, 4'd8},   // R8 back in idle, clear accepted
        '{18'h055F0, 32'h11, 32'h400, 4'd7},   // R7 load outside page mode
        '{18'h05554, 32'hF5, 32'h000, 4'd4},   // R4
        '{18'h05554, 32'h50, 32'h040, 4'd5},   // R5
        '{18'h055F0, 32'h22, 32'h040, 4'd5},   // R5 low word
        '{18'h055F0, 32'h33, 32'h440, 4'd7},   // R7 low word twice
        '{18'h05554, 32'hF5, 32'h000, 4'd4},   // R4
        '{18'h05554, 32'hAA, 32'h000, 4'd12},  // R12 step 1
        '{18'h0AAA8, 32'h55, 32'h000, 4'd12},  // R12 step 2
        '{18'h0553C, 32'h03, 32'h400, 4'd12}   // R12 level 3 rejected
    };

    task automatic chk(input logic [31:0] exp, input string req);
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL %s status=%h expected=%h", req, status, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] dt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(18'h05554, 32'hAA);
        wr(18'h0AAA8, 32'h55);
    endtask

    task automatic erase(input logic [ADDR_W-1:0] base, input logic [31:0] kind);
        unlock();
        wr(18'h05554, 32'h80);
        unlock();
        wr(base, kind);
    endtask

    task automatic load_pairs(input int n);
        for (int i = 0; i < n; i++) begin
            wr(18'h055F0, 32'h100 + i);
            wr(18'h055F4, 32'h200 + i);
        end
    endtask

    task automatic page_write(input logic [ADDR_W-1:0] base);
        unlock();
        wr(18'h05554, 32'hA0);
        wr(base, 32'hAA);
    endtask

    task automatic unprotect(input logic [31:0] a, input logic [31:0] b);
        unlock();
        wr(18'h0553C, 32'h1);
        wr(18'h0AAA8, a);
        wr(18'h0AAA8, b);
        wr(18'h05558, 32'h05);
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        chk(32'h0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'h0, "R1 after release");

        foreach (VECS[i]) begin
            wr(VECS[i].a, VECS[i].d);
            checks++;
            if (status !== VECS[i].e) begin
                errors++;
                $display("FAIL R%0d vector %0d status=%h expected=%h", VECS[i].r, i, status, VECS[i].e);
            end
        end
        wr(18'h05554, 32'hF5);
        chk(32'h0, "R4 clear after vectors");

        // R2 normal sector erase, R3 busy width
        erase(18'h0C000, 32'h30);
        chk(32'h21, "R2 erase start");
        hi = 0;
        while (status[0] && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        checks++;
        if (hi != BUSY) begin
            errors++;
            $display("FAIL R3 busy cycles=%0d expected=%0d", hi, BUSY);
        end
        chk(32'h20, "R3 busy cleared, erase flag kept");

        // R9 write during busy
        erase(18'h00000, 32'hC0);
        chk(32'h21, "R2 config block erase");
        wr(18'h05554, 32'hAA);
        chk(32'h421, "R9 write while busy");
        wait_idle();
        wr(18'h05554, 32'hF5);
        chk(32'h0, "R4 clear after busy");

        // R5/R6 page program
        wr(18'h05554, 32'h50);
        load_pairs(PAIRS);
        chk(32'h40, "R5 buffer full, page mode held");
        page_write(18'h04100);
        chk(32'h11, "R6 program start");
        wait_idle();
        wr(18'h05554, 32'hF5);

        // R7 too few pairs, then no page mode
        wr(18'h05554, 32'h50);
        load_pairs(3);
        page_write(18'h04100);
        chk(32'h440, "R7 short buffer");
        wr(18'h05554, 32'hF5);
        page_write(18'h04100);
        chk(32'h400, "R7 no page mode");
        wr(18'h05554, 32'hF5);

        // R10 locked sector, R11 unprotect
        sect_lock = 16'h0008;
        erase(18'h0C000, 32'h30);
        chk(32'h800, "R10 locked erase refused");
        unprotect(PWA, 32'h0BAD_0BAD);
        chk(32'h800, "R11 wrong password");
        unprotect(PWA, PWB);
        chk(32'h2000800, "R11 unprotect accepted");
        erase(18'h0C000, 32'h30);
        chk(32'h2000821, "R10 erase after unprotect");
        wait_idle();
        wr(18'h05554, 32'hF5);
        chk(32'h2000000, "R4 clear keeps protection-disabled flag");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule